// File: doc/BRIEF.md
# Verified Address Window Switcher

This block points a host-visible address window at one of several on-chip cores. A client asks for a core by its index. The block then writes the window base register through a small register port. It reads the register back and turns the readback into a core index. It accepts the switch only when that index equals the one requested. If the two do not match, the block waits a fixed time of about ten microseconds and tries again. It gives up after a bounded number of attempts. An access error on the register port ends the switch at once.

The block remembers which core the window currently maps. A request for that same core completes on the next cycle and makes no register traffic. Any failed switch clears this record, because after a failure the window contents are unknown. Only one switch runs at a time. The request side stays not-ready until the switch reports done or error.

Top module: `win_switch`

## Requirements
- R1: After reset, `req_ready` is 1, `done` and `err` are 0, `map_vld` is 0, and neither `reg_wr` nor `reg_rd` is asserted.
- R2: The value written for core index k is `ENUM_BASE + k * 2**CORE_SHIFT`. The defaults are base 0x1800_0000 and a 4096-byte core size, so index 15 writes 0x1800_F000.
- R3: Every successful register write is followed by one register read. A readback whose `(rdata - ENUM_BASE) >> CORE_SHIFT` equals the requested index ends the switch with `done`. It also sets `map_vld` to 1 and `map_idx` to that index.
- R4: When the readback does not match, the next write comes at least `CLK_MHZ * WAIT_US` cycles after the previous write completed.
- R5: After `MAX_RETRY + 1` mismatching readbacks, the switch ends with `err` and makes no further writes.
- R6: If `reg_err` is returned with the write acknowledge, the switch ends with `err` at once, with no readback and no retry.
- R7: If `reg_err` is returned with the read acknowledge, the switch ends with `err` at once, with no retry.
- R8: A request for the index that is already mapped (while `map_vld` is 1) gives `done` in the cycle after it is accepted, with no register access.
- R9: Every `err` clears `map_vld`. A later request for the previously mapped index then performs a full switch.
- R10: `req_ready` is 0 from the moment a switch starts until it ends.
- R11: `done` and `err` are single-cycle pulses and are never high together.
- R12: `reg_wr` and `reg_rd` are never both high. A strobe stays high with `reg_wdata` stable until `reg_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Switch request |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_idx | input | IDX_W | Requested core index |
| done | output | 1 | Pulse: switch completed or skipped |
| err | output | 1 | Pulse: switch failed |
| map_vld | output | 1 | A core is known to be mapped |
| map_idx | output | IDX_W | Index of the mapped core |
| reg_wr | output | 1 | Window register write strobe |
| reg_rd | output | 1 | Window register read strobe |
| reg_wdata | output | ADDR_W | Window base value to write |
| reg_rdata | input | ADDR_W | Readback value, valid with reg_ack on a read |
| reg_ack | input | 1 | Register access complete |
| reg_err | input | 1 | Register access failed, valid with reg_ack |

## Verification
The bench aims at the retry path. A register model ignores a set number of writes. This shows whether the design waits the full interval between attempts, and whether it stops after exactly one more attempt than the retry limit. An off-by-one counter would give one write too many or too few. It also checks that an already-mapped index is served without any register traffic, and that the mapping is forgotten after an error. A design that kept a stale record would report success without moving the window. Write errors and read errors are injected separately. A design that ignored either one would read back after a failed write, or would keep retrying.

// File: rtl/win_switch.sv
module win_switch #(
  parameter int IDX_W = 4,
  parameter int ADDR_W = 32,
  parameter int CORE_SHIFT = 12,
  parameter logic [ADDR_W-1:0] ENUM_BASE = 32'h1800_0000,
  parameter int MAX_RETRY = 3,
  parameter int CLK_MHZ = 125,
  parameter int WAIT_US = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx,
  output logic              done,
  output logic              err,
  output logic              map_vld,
  output logic [IDX_W-1:0]  map_idx,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_rdata,
  input  logic              reg_ack,
  input  logic              reg_err
);

  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int WCNT_W = $clog2(WAIT_CYC + 1);
  localparam int TRY_W = $clog2(MAX_RETRY + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_WAIT} state_t;

  state_t state;
  logic [IDX_W-1:0] tgt;
  logic [TRY_W-1:0] tries;
  logic [WCNT_W-1:0] wcnt;
  logic [ADDR_W-1:0] rb_off;
  logic match, hit;

  assign req_ready = (state == S_IDLE);
  assign reg_wr = (state == S_WR);
  assign reg_rd = (state == S_RD);
  assign reg_wdata = ENUM_BASE + (ADDR_W'(tgt) << CORE_SHIFT);
  assign rb_off = reg_rdata - ENUM_BASE;
  assign match = (rb_off >> CORE_SHIFT) == ADDR_W'(tgt);
  assign hit = map_vld && (map_idx == req_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tgt <= '0;
      tries <= '0;
      wcnt <= '0;
      done <= 1'b0;
      err <= 1'b0;
      map_vld <= 1'b0;
      map_idx <= '0;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      case (state)
        S_IDLE:
          if (req_valid) begin
            tgt <= req_idx;
            tries <= '0;
            if (hit) done <= 1'b1;
            else state <= S_WR;
          end
        S_WR:
          if (reg_ack) begin
            if (reg_err) begin
              err <= 1'b1;
              map_vld <= 1'b0;
              state <= S_IDLE;
            end else begin
              state <= S_RD;
            end
          end
        S_RD:
          if (reg_ack) begin
            if (reg_err) begin
              err <= 1'b1;
              map_vld <= 1'b0;
              state <= S_IDLE;
            end else if (match) begin
              done <= 1'b1;
              map_vld <= 1'b1;
              map_idx <= tgt;
              state <= S_IDLE;
            end else if (tries == TRY_W'(MAX_RETRY)) begin
              err <= 1'b1;
              map_vld <= 1'b0;
              state <= S_IDLE;
            end else begin
              tries <= tries + 1'b1;
              wcnt <= '0;
              state <= S_WAIT;
            end
          end
        S_WAIT:
          if (wcnt == WCNT_W'(WAIT_CYC - 1)) state <= S_WR;
          else wcnt <= wcnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd}));

  // R12
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_ack) |=> (reg_wr && $stable(reg_wdata)));

  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || req_ready);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> !req_ready);

  // R3
  done_mapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> map_vld);

  // R9
  err_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !map_vld);

  // R6
  wr_fail_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_ack && reg_err) |=> (err && !reg_rd));

endmodule

// File: tb/test_win_switch.sv
module test_win_switch;
  localparam int IDX_W = 4;
  localparam int ADDR_W = 32;
  localparam logic [31:0] BASE = 32'h1800_0000;
  localparam int MAX_RETRY = 3;
  localparam int WAIT_CYC = 125 * 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [IDX_W-1:0] req_idx = '0;
  logic req_ready, done, err, map_vld, reg_wr, reg_rd;
  logic [IDX_W-1:0] map_idx;
  logic [ADDR_W-1:0] reg_wdata;
  logic [ADDR_W-1:0] reg_rdata = '0;
  logic reg_ack = 1'b0;
  logic reg_err = 1'b0;

  int checks = 0, errors = 0;
  int cyc = 0;
  int wr_cnt = 0, rd_cnt = 0, last_wr_cyc = 0, min_gap = 0;
  int stale = 0, ack_dly = 0, hold = 0, stab_bad = 0;
  bit wfail = 0, rfail = 0;
  logic [31:0] win = '0, last_wd = '0, first_wd = '0;
  int res_cyc;
  bit res_ok, res_err, mid_ready, done_after;

  always #4 clk = ~clk;

  win_switch i_win_switch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .done(done), .err(err), .map_vld(map_vld),
    .map_idx(map_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .reg_err(reg_err)
  );

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (reg_ack) begin
        reg_ack = 1'b0;
        reg_err = 1'b0;
      end else if (reg_wr || reg_rd) begin
        if (hold == 0) first_wd = reg_wdata;
        else if (reg_wr && reg_wdata != first_wd) stab_bad++;
        if (hold < ack_dly) hold++;
        else begin
          hold = 0;
          reg_ack = 1'b1;
          if (reg_wr) begin
            if (wr_cnt > 0 && (cyc - last_wr_cyc) < min_gap) min_gap = cyc - last_wr_cyc;
            wr_cnt++;
            last_wr_cyc = cyc;
            last_wd = reg_wdata;
            reg_err = wfail;
            if (!wfail) begin
              if (stale > 0) stale--;
              else win = reg_wdata;
            end
          end else begin
            rd_cnt++;
            reg_rdata = win;
            reg_err = rfail;
          end
        end
      end
    end
  end

  task automatic chk(input bit c, input string req, input longint act, input longint exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_switch(input logic [IDX_W-1:0] idx);
    wr_cnt = 0; rd_cnt = 0; min_gap = 1 << 30;
    while (!req_ready) @(negedge clk);
    req_idx = idx;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    res_cyc = 1;
    mid_ready = 1'b0;
    while (!done && !err && res_cyc < 20000) begin
      @(negedge clk);
      res_cyc++;
      if (res_cyc == 3) mid_ready = req_ready;
    end
    res_ok = done;
    res_err = err;
    @(negedge clk);
    done_after = done || err;
  endtask

  task automatic t_reset;
    chk(req_ready == 1 && done == 0 && err == 0, "R1 idle outputs", {req_ready, done, err}, 3'b100);
    chk(map_vld == 0 && reg_wr == 0 && reg_rd == 0, "R1 no map, no strobes", {map_vld, reg_wr, reg_rd}, 0);
  endtask

  task automatic t_clean;
    run_switch(4'd3);
    chk(res_ok && !res_err, "R3 clean switch done", res_ok, 1);
    chk(last_wd == BASE + 32'h3000, "R2 window value idx 3", last_wd, BASE + 32'h3000);
    chk(wr_cnt == 1 && rd_cnt == 1, "R3 one write one read", wr_cnt * 16 + rd_cnt, 17);
    chk(map_vld && map_idx == 3, "R3 mapped index", map_idx, 3);
    chk(!done_after, "R11 done single pulse", done_after, 0);
  endtask

  task automatic t_hit;
    run_switch(4'd3);
    chk(res_ok && res_cyc == 1, "R8 hit latency", res_cyc, 1);
    chk(wr_cnt == 0 && rd_cnt == 0, "R8 no register traffic", wr_cnt + rd_cnt, 0);
  endtask

  task automatic t_retry;
    stale = 2;
    ack_dly = 2;
    run_switch(4'd5);
    ack_dly = 0;
    chk(res_ok, "R4 switch succeeds after retries", res_ok, 1);
    chk(wr_cnt == 3, "R4 three writes", wr_cnt, 3);
    chk(min_gap >= WAIT_CYC, "R4 wait between writes", min_gap, WAIT_CYC);
    chk(mid_ready == 0, "R10 not ready during switch", mid_ready, 0);
    chk(stab_bad == 0, "R12 wdata held until ack", stab_bad, 0);
    chk(map_idx == 5, "R3 mapped after retry", map_idx, 5);
  endtask

  task automatic t_exhaust;
    stale = 100;
    run_switch(4'd7);
    stale = 0;
    chk(res_err && !res_ok, "R5 error after retries", res_err, 1);
    chk(wr_cnt == MAX_RETRY + 1, "R5 attempt count", wr_cnt, MAX_RETRY + 1);
    chk(!map_vld, "R9 map cleared on error", map_vld, 0);
    chk(!done_after, "R11 err single pulse", done_after, 0);
  endtask

  task automatic t_after_err;
    run_switch(4'd5);
    chk(res_ok && wr_cnt == 1, "R9 full switch after error", wr_cnt, 1);
  endtask

  task automatic t_wfail;
    wfail = 1;
    run_switch(4'd2);
    wfail = 0;
    chk(res_err && wr_cnt == 1 && rd_cnt == 0, "R6 write error aborts", wr_cnt * 16 + rd_cnt, 16);
    chk(!map_vld, "R9 map cleared after write error", map_vld, 0);
  endtask

  task automatic t_rfail;
    rfail = 1;
    run_switch(4'd2);
    rfail = 0;
    chk(res_err && wr_cnt == 1 && rd_cnt == 1, "R7 read error aborts", wr_cnt * 16 + rd_cnt, 17);
  endtask

  task automatic t_top_idx;
    run_switch(4'd15);
    chk(res_ok && last_wd == BASE + 32'hF000, "R2 window value idx 15", last_wd, BASE + 32'hF000);
    chk(map_idx == 15, "R3 mapped top index", map_idx, 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_hit();
    t_retry();
    t_exhaust();
    t_after_err();
    t_wfail();
    t_rfail();
    t_top_idx();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule